// File: doc/BRIEF.md
# I2S Stereo Audio Transceiver

This block moves 16-bit stereo audio between a parallel sample interface and a three-wire serial audio link in I2S format. It runs entirely from an audio master clock at 256 times the base sampling rate. From that clock it makes the bit clock and the word-select clock. Each frame has two 16-bit slots, so the bit clock runs at 32 times the sampling rate. One transmit holding register takes a left/right pair over a ready/valid handshake and feeds a 32-bit shifter. That shifter drives the serial data output. A receive shifter collects the serial input and delivers each complete pair over a second ready/valid handshake.

Static configuration inputs set three things. The rate input scales the sampling rate to full, one half or one quarter of the base rate. A delay option places the first data bit one bit clock after the word-select edge, as standard I2S does, or directly on that edge. A swap option exchanges which word-select level carries the left channel. These inputs are meant to change only while reset is asserted. Two sticky flags report problems. One shows a transmit frame that started with nothing to send. The other shows a received pair that was overwritten before it was read.

Top module: `stereo_serial_xcvr`

## Requirements
- R1: While `rst` is high and after it is released, the outputs are as follows until the first bit-clock edge: `bclk_o`=0, `wsel_o`=1, `sdata_o`=0, `tx_ready`=1, `rx_valid`=0, `tx_underrun`=0 and `rx_overrun`=0. The first falling edge of `bclk_o` starts a word-select-low slot.
- R2: One half period of `bclk_o` lasts 4·2^k master clocks. For `cfg_rate` = 0, 1, 2, k is 0, 1, 2, and value 3 acts as 2. This gives division by 8, 16 or 32. `wsel_o` changes only on a falling edge of `bclk_o`. It stays low for 16 bit periods, then high for 16.
- R3: Each sample is sent MSB first, and `sdata_o` changes only on falling edges of `bclk_o`. With `cfg_one_bit_delay`=0, the MSB occupies the first bit period of its slot. With `cfg_one_bit_delay`=1, every bit moves one bit period later, and the LSB falls in the first bit period of the following slot.
- R4: With `cfg_swap_lr`=0, the left sample travels in the word-select-low slot and the right sample in the word-select-high slot. With `cfg_swap_lr`=1, the two slots are exchanged. This applies to both directions.
- R5: `tx_ready` is high exactly when the holding register is empty. A pair is taken when `tx_valid` and `tx_ready` are both high on a clock edge. The holding register is emptied into the shifter at each frame start, which is the first data bit of the low-slot word. Pairs go out in the order they were accepted.
- R6: If a frame starts while the holding register is empty, all 32 bits of that frame are 0 and `tx_underrun` goes to 1. It stays at 1 until reset.
- R7: `sdata_i` is sampled on rising edges of `bclk_o`, using the same bit order, delay and slot placement as transmit. Each complete 32-bit frame becomes one pair on `rx_left`/`rx_right`.
- R8: A pair stays presented with `rx_valid`=1 until it is read with `rx_ready`. A read and a new capture can fall on the same edge. In that case the old pair is the one read, the new pair becomes the presented one, and `rx_overrun` is not set.
- R9: A capture while an unread pair is still held replaces that pair with the new one and sets `rx_overrun`. The flag stays at 1 until reset.
- R10: The partial frame in progress when reset is released is never delivered. The first pair presented is the first frame whose every bit was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock, 256×base fs |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rate | input | 2 | Rate scaling: 0 full, 1 half, 2 or 3 quarter |
| cfg_one_bit_delay | input | 1 | 1: data one bit clock after the word-select edge |
| cfg_swap_lr | input | 1 | 1: left channel in the word-select-high slot |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_left | input | 16 | Transmit left sample |
| tx_right | input | 16 | Transmit right sample |
| rx_valid | output | 1 | Received pair held |
| rx_ready | input | 1 | Consumer takes the held pair |
| rx_left | output | 16 | Received left sample |
| rx_right | output | 16 | Received right sample |
| tx_underrun | output | 1 | Sticky: a frame started with nothing to send |
| rx_overrun | output | 1 | Sticky: an unread pair was overwritten |
| bclk_o | output | 1 | Serial bit clock |
| wsel_o | output | 1 | Word-select clock |
| sdata_o | output | 1 | Serial transmit data |
| sdata_i | input | 1 | Serial receive data |

## Verification
Two receive-side actions can fall on the same master-clock edge: the consumer reading the held pair, and the capture of the next frame at the end of its last bit. The bench holds `rx_ready` low while frame 3 is pending. It then raises `rx_ready` on the falling clock edge just before the bit-clock rising edge that completes frame 4. The bench computes that edge itself from its count of bit-clock periods. The result passes only if frames 3 and 4 are both read, in order, and `rx_overrun` is still 0 afterwards. Later, a deliberate two-frame stall must set the flag and leave only the newer pair. The sweep covers every combination of rate, delay and swap.

// File: rtl/sxv_pkg.sv
package sxv_pkg;

    // Sample and frame geometry
    localparam int unsigned SAMPLE_W       = 16;
    localparam int unsigned FRAME_W        = 2 * SAMPLE_W;
    localparam int unsigned POS_W          = $clog2(FRAME_W);

    // Half bit period at full rate is 2**BASE_HALF_LOG2 master clocks
    localparam int unsigned BASE_HALF_LOG2 = 2;
    localparam int unsigned MAX_SCALE_LOG2 = 2;
    localparam int unsigned DIV_W          = BASE_HALF_LOG2 + MAX_SCALE_LOG2;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [FRAME_W-1:0]  frame_t;
    typedef logic [POS_W-1:0]    pos_t;
    typedef logic [DIV_W-1:0]    div_t;

    typedef enum logic [1:0] {
        RATE_X1       = 2'd0,
        RATE_X2       = 2'd1,
        RATE_X4       = 2'd2,
        RATE_X4_ALIAS = 2'd3
    } rate_e;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } stereo_t;

    typedef struct packed {
        rate_e rate;
        logic  one_bit_delay;
        logic  swap_lr;
    } cfg_t;

    // Last count value of the half-period prescaler for a rate setting
    function automatic div_t half_limit(rate_e r);
        int unsigned scale;
        scale = (r == RATE_X4_ALIAS) ? MAX_SCALE_LOG2 : int'(unsigned'(r));
        return div_t'((32'd1 << (BASE_HALF_LOG2 + scale)) - 32'd1);
    endfunction

    // Slot 0 (word select low) is sent first
    function automatic frame_t pack_frame(stereo_t p, logic swap);
        return swap ? {p.right, p.left} : {p.left, p.right};
    endfunction

    function automatic stereo_t unpack_frame(frame_t f, logic swap);
        stereo_t p;
        if (swap) begin
            p.left  = f[SAMPLE_W-1:0];
            p.right = f[FRAME_W-1:SAMPLE_W];
        end else begin
            p.left  = f[FRAME_W-1:SAMPLE_W];
            p.right = f[SAMPLE_W-1:0];
        end
        return p;
    endfunction

endpackage

// File: rtl/sxv_clkgen.sv
module sxv_clkgen
    import sxv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rate_e rate,
    output logic  bclk,
    output pos_t  pos,
    output logic  rise_ev,
    output logic  fall_ev
);

    div_t div_q;
    logic wrap;

    assign wrap    = (div_q == half_limit(rate));
    assign rise_ev = wrap && !bclk;
    assign fall_ev = wrap && bclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            bclk  <= 1'b0;
            pos   <= '1;        // first falling edge moves to position 0
        end else if (wrap) begin
            div_q <= '0;
            bclk  <= ~bclk;
            if (bclk) begin
                pos <= pos + pos_t'(1);
            end
        end else begin
            div_q <= div_q + div_t'(1);
        end
    end

endmodule

// File: rtl/sxv_tx.sv
module sxv_tx
    import sxv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fall_ev,
    input  pos_t    pos,
    input  cfg_t    cfg,
    input  logic    in_valid,
    output logic    in_ready,
    input  stereo_t in_pair,
    output logic    sd,
    output logic    underrun
);

    logic    held_q;
    stereo_t hold_q;
    frame_t  shift_q;

    pos_t    next_pos;
    pos_t    data_idx;
    logic    frame_start;
    logic    accept;
    frame_t  fresh;

    always_comb begin
        next_pos    = pos + pos_t'(1);
        data_idx    = next_pos - pos_t'(cfg.one_bit_delay);
        frame_start = fall_ev && (data_idx == '0);
        accept      = in_valid && !held_q;
        fresh       = held_q ? pack_frame(hold_q, cfg.swap_lr) : '0;
    end

    assign in_ready = !held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= 1'b0;
            hold_q   <= '0;
            shift_q  <= '0;
            sd       <= 1'b0;
            underrun <= 1'b0;
        end else begin
            // An accept needs an empty register, so it cannot meet a pending load
            if (accept) begin
                held_q <= 1'b1;
                hold_q <= in_pair;
            end else if (frame_start) begin
                held_q <= 1'b0;
            end

            if (frame_start && !held_q) begin
                underrun <= 1'b1;
            end

            if (fall_ev) begin
                if (frame_start) begin
                    sd      <= fresh[FRAME_W-1];
                    shift_q <= {fresh[FRAME_W-2:0], 1'b0};
                end else begin
                    sd      <= shift_q[FRAME_W-1];
                    shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/sxv_rx.sv
module sxv_rx
    import sxv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rise_ev,
    input  pos_t    pos,
    input  cfg_t    cfg,
    input  logic    sd,
    output logic    out_valid,
    input  logic    out_ready,
    output stereo_t out_pair,
    output logic    overrun
);

    frame_t shift_q;
    logic   armed_q;

    pos_t   data_idx;
    frame_t assembled;
    logic   capture;
    logic   consume;

    always_comb begin
        data_idx  = pos - pos_t'(cfg.one_bit_delay);
        assembled = {shift_q[FRAME_W-2:0], sd};
        capture   = rise_ev && armed_q && (data_idx == pos_t'(FRAME_W - 1));
        consume   = out_valid && out_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q   <= '0;
            armed_q   <= 1'b0;
            out_valid <= 1'b0;
            out_pair  <= '0;
            overrun   <= 1'b0;
        end else begin
            if (rise_ev) begin
                shift_q <= assembled;
                // Arm only once a frame's first bit is seen
                if (data_idx == '0) begin
                    armed_q <= 1'b1;
                end
            end

            if (capture) begin
                out_pair  <= unpack_frame(assembled, cfg.swap_lr);
                out_valid <= 1'b1;
                if (out_valid && !consume) begin
                    overrun <= 1'b1;
                end
            end else if (consume) begin
                out_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/stereo_serial_xcvr.sv
module stereo_serial_xcvr
    import sxv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_rate,
    input  logic                cfg_one_bit_delay,
    input  logic                cfg_swap_lr,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                rx_valid,
    input  logic                rx_ready,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                tx_underrun,
    output logic                rx_overrun,
    output logic                bclk_o,
    output logic                wsel_o,
    output logic                sdata_o,
    input  logic                sdata_i
);

    cfg_t    cfg;
    pos_t    pos;
    logic    rise_ev;
    logic    fall_ev;
    stereo_t tx_pair;
    stereo_t rx_pair;

    assign cfg.rate          = rate_e'(cfg_rate);
    assign cfg.one_bit_delay = cfg_one_bit_delay;
    assign cfg.swap_lr       = cfg_swap_lr;

    assign tx_pair.left  = tx_left;
    assign tx_pair.right = tx_right;
    assign rx_left       = rx_pair.left;
    assign rx_right      = rx_pair.right;

    // Upper position bit selects the slot
    assign wsel_o = pos[POS_W-1];

    sxv_clkgen u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .rate    (cfg.rate),
        .bclk    (bclk_o),
        .pos     (pos),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    sxv_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .fall_ev  (fall_ev),
        .pos      (pos),
        .cfg      (cfg),
        .in_valid (tx_valid),
        .in_ready (tx_ready),
        .in_pair  (tx_pair),
        .sd       (sdata_o),
        .underrun (tx_underrun)
    );

    sxv_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .rise_ev   (rise_ev),
        .pos       (pos),
        .cfg       (cfg),
        .sd        (sdata_i),
        .out_valid (rx_valid),
        .out_ready (rx_ready),
        .out_pair  (rx_pair),
        .overrun   (rx_overrun)
    );

endmodule

// File: rtl/sxv_chk.sv
module sxv_chk (
    input logic clk,
    input logic rst,
    input logic bclk,
    input logic wsel,
    input logic sdata,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic rx_ready,
    input logic tx_underrun,
    input logic rx_overrun
);

    a_r2_wsel_on_fall: assert property (@(posedge clk) disable iff (rst)
        (wsel != $past(wsel)) |-> $fell(bclk));

    a_r3_sdata_on_fall: assert property (@(posedge clk) disable iff (rst)
        (sdata != $past(sdata)) |-> $fell(bclk));

    a_r5_accept_fills: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    a_r6_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
        tx_underrun |=> tx_underrun);

    a_r8_held_until_read: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> rx_valid);

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |=> rx_overrun);

endmodule

bind stereo_serial_xcvr sxv_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bclk        (bclk_o),
    .wsel        (wsel_o),
    .sdata       (sdata_o),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .tx_underrun (tx_underrun),
    .rx_overrun  (rx_overrun)
);

// File: tb/stereo_serial_xcvr_tb.sv
`timescale 1ns/1ps
module stereo_serial_xcvr_tb;

    localparam int NTX     = 5;    // pairs fed to the transmitter
    localparam int NRX     = 8;    // frames driven into the receiver
    localparam int END_POS = 262;  // stream bit index that ends one run

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_rate = 2'd0;
    logic        cfg_one_bit_delay = 1'b0;
    logic        cfg_swap_lr = 1'b0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [15:0] tx_left = 16'h0;
    logic [15:0] tx_right = 16'h0;
    logic        rx_valid;
    logic        rx_ready = 1'b0;
    logic [15:0] rx_left;
    logic [15:0] rx_right;
    logic        tx_underrun;
    logic        rx_overrun;
    logic        bclk_o;
    logic        wsel_o;
    logic        sdata_o;
    logic        sdata_i = 1'b0;

    always #2.5 clk = ~clk;

    stereo_serial_xcvr u_dut (
        .clk               (clk),
        .rst               (rst),
        .cfg_rate          (cfg_rate),
        .cfg_one_bit_delay (cfg_one_bit_delay),
        .cfg_swap_lr       (cfg_swap_lr),
        .tx_valid          (tx_valid),
        .tx_ready          (tx_ready),
        .tx_left           (tx_left),
        .tx_right          (tx_right),
        .rx_valid          (rx_valid),
        .rx_ready          (rx_ready),
        .rx_left           (rx_left),
        .rx_right          (rx_right),
        .tx_underrun       (tx_underrun),
        .rx_overrun        (rx_overrun),
        .bclk_o            (bclk_o),
        .wsel_o            (wsel_o),
        .sdata_o           (sdata_o),
        .sdata_i           (sdata_i)
    );

    int checks = 0;
    int errors = 0;

    int   cfgid, half;
    logic dly, swp;
    int   fall_cnt, cyc, tick, last_rise, exp_rd, n_rd;
    logic prev_sck;
    bit   mon_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] tx_pat(int c, int n, bit right);
        return 16'(32'h8001 + c * 32'h0107 + n * 32'h2469 + (right ? 32'h4C3B : 32'h0));
    endfunction

    function automatic logic [15:0] rx_pat(int c, int n, bit right);
        return 16'(32'h8003 + c * 32'h0309 + n * 32'h1D35 + (right ? 32'h5A17 : 32'h0)) ^ 16'h0F0F;
    endfunction

    // R4: slot 0 (word select low) carries left unless swapped
    function automatic logic [31:0] slots(logic [15:0] l, logic [15:0] r);
        return swp ? {r, l} : {l, r};
    endfunction

    function automatic logic [31:0] tx_frame(int n);
        if (n < 0 || n >= NTX) return 32'h0;
        return slots(tx_pat(cfgid, n, 1'b0), tx_pat(cfgid, n, 1'b1));
    endfunction

    function automatic logic [31:0] rx_frame(int n);
        if (n < 0 || n >= NRX) return 32'h0;
        return slots(rx_pat(cfgid, n, 1'b0), rx_pat(cfgid, n, 1'b1));
    endfunction

    // Serial partner model: decodes sdata_o, drives sdata_i, paces rx_ready
    int          s;
    logic [31:0] fr;
    logic        ebit;
    logic        rdy;
    always @(negedge clk) begin
        if (mon_on) begin
            tick++;
            if (bclk_o && !prev_sck) begin
                if (last_rise >= 0)
                    chk(tick - last_rise == 2 * half, "R2 bit clock period", tick - last_rise, 2 * half);
                last_rise = tick;
                if (fall_cnt < 0) begin
                    chk(wsel_o == 1'b1, "R1 word select before first fall", int'(wsel_o), 1);
                end else begin
                    s    = fall_cnt - int'(dly);
                    fr   = (s < 0) ? 32'h0 : tx_frame(s / 32);
                    ebit = (s < 0) ? 1'b0 : fr[31 - (s % 32)];
                    chk(sdata_o == ebit, "R3 R4 R5 transmit bit", int'(sdata_o), int'(ebit));
                    chk(wsel_o == ((fall_cnt % 32) >= 16), "R1 R2 word select level",
                        int'(wsel_o), int'((fall_cnt % 32) >= 16));
                end
            end
            if (!bclk_o && prev_sck) begin
                fall_cnt++;
                cyc = 0;
                s   = fall_cnt - int'(dly);
                fr  = (s < 0) ? 32'h0 : rx_frame(s / 32);
                sdata_i = (s < 0) ? 1'b0 : fr[31 - (s % 32)];
                if (s == 150)
                    chk(tx_underrun == 1'b0, "R6 no underrun while fed", int'(tx_underrun), 0);
                if (s == 165)
                    chk(tx_underrun == 1'b1, "R6 underrun after holding ran dry", int'(tx_underrun), 1);
                if (s == 200) begin
                    chk(rx_overrun == 1'b0, "R8 same-edge read and capture leave overrun clear", int'(rx_overrun), 0);
                    chk(rx_valid == 1'b1, "R8 pending pair presented", int'(rx_valid), 1);
                    chk(rx_left == rx_pat(cfgid, 5, 1'b0), "R7 pending left", int'(rx_left), int'(rx_pat(cfgid, 5, 1'b0)));
                end
                if (s == 230) begin
                    chk(rx_overrun == 1'b1, "R9 overrun after overwrite", int'(rx_overrun), 1);
                    chk(rx_left == rx_pat(cfgid, 6, 1'b0), "R9 newest left kept", int'(rx_left), int'(rx_pat(cfgid, 6, 1'b0)));
                    chk(rx_right == rx_pat(cfgid, 6, 1'b1), "R9 newest right kept", int'(rx_right), int'(rx_pat(cfgid, 6, 1'b1)));
                end
            end
            cyc++;
            s = fall_cnt - int'(dly);
            if (fall_cnt < 0 || s < 106)      rdy = 1'b1;
            else if (s < 159)                 rdy = 1'b0;
            else if (s == 159)                rdy = (cyc >= half);
            else if (s < 170)                 rdy = 1'b1;
            else if (s < 230)                 rdy = 1'b0;
            else                              rdy = 1'b1;
            rx_ready = rdy;
            if (rx_valid && rx_ready) begin
                chk(rx_left == rx_pat(cfgid, exp_rd, 1'b0), "R7 R10 received left",
                    int'(rx_left), int'(rx_pat(cfgid, exp_rd, 1'b0)));
                chk(rx_right == rx_pat(cfgid, exp_rd, 1'b1), "R7 R10 received right",
                    int'(rx_right), int'(rx_pat(cfgid, exp_rd, 1'b1)));
                n_rd++;
                exp_rd = (exp_rd == 4) ? 6 : exp_rd + 1;
            end
            prev_sck = bclk_o;
        end
    end

    task automatic feed();
        for (int k = 0; k < NTX; k++) begin
            @(negedge clk);
            while (!tx_ready) @(negedge clk);
            tx_valid = 1'b1;
            tx_left  = tx_pat(cfgid, k, 1'b0);
            tx_right = tx_pat(cfgid, k, 1'b1);
            @(negedge clk);
            tx_valid = 1'b0;
        end
    endtask

    task automatic run_cfg(input int r, input bit d, input bit w);
        mon_on            = 1'b0;
        rst               = 1'b1;
        cfg_rate          = 2'(r);
        cfg_one_bit_delay = d;
        cfg_swap_lr       = w;
        tx_valid          = 1'b0;
        rx_ready          = 1'b0;
        sdata_i           = 1'b0;
        cfgid = r * 4 + int'(d) * 2 + int'(w);
        dly   = d;
        swp   = w;
        half  = 4 << ((r == 3) ? 2 : r);
        repeat (3) @(negedge clk);
        chk(bclk_o == 1'b0 && wsel_o == 1'b1 && sdata_o == 1'b0, "R1 serial outputs in reset",
            int'({bclk_o, wsel_o, sdata_o}), 3'b010);
        chk(tx_ready == 1'b1 && rx_valid == 1'b0, "R1 handshakes in reset",
            int'({tx_ready, rx_valid}), 2'b10);
        chk(tx_underrun == 1'b0 && rx_overrun == 1'b0, "R1 flags clear in reset",
            int'({tx_underrun, rx_overrun}), 0);
        fall_cnt  = -1;
        cyc       = 0;
        tick      = 0;
        last_rise = -1;
        prev_sck  = 1'b0;
        exp_rd    = 0;
        n_rd      = 0;
        rst       = 1'b0;
        mon_on    = 1'b1;
        fork
            feed();
            wait (fall_cnt - int'(dly) >= END_POS);
        join
        mon_on = 1'b0;
        chk(n_rd == 7, "R8 R10 pairs delivered", n_rd, 7);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < 4; r++)
            for (int d = 0; d < 2; d++)
                for (int w = 0; w < 2; w++)
                    run_cfg(r, d[0], w[0]);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule